// File: doc/BRIEF.md
# Packed Lane-Mask Integer ALU

A single-cycle integer execution unit that works on one 32-bit word, on two packed 16-bit half-words or on four packed 8-bit bytes, with the lane size picked per operation. It keeps no condition flags. Comparisons write a mask into the destination instead, with every bit of a lane set when the condition holds and every bit clear otherwise. Later masking and branch logic can use that mask directly.

The arithmetic set covers saturating addition and subtraction and halving addition and subtraction, each in a signed and an unsigned form. Both source operands are read-only, and one separate result word is produced. The combinational datapath feeds a result register. The result and its valid strobe appear one clock after the input is accepted.

Top module: `lmalu_top`

## Requirements
- R1: Reset clears `out_vld` and `out_res`. `out_vld` equals `in_vld` of the previous clock. `out_res` loads only on a cycle with `in_vld` high and otherwise keeps its value.
- R2: Lane size `lane_sz` is decoded as follows: 2'b00 is one 32-bit lane, 2'b01 is two 16-bit lanes (lane 0 in bits 15:0) and 2'b10 is four 8-bit lanes (lane 0 in bits 7:0). Each lane is computed from its own operand bits only, with no carry or borrow crossing a lane edge.
- R3: A `lane_sz` of 2'b11, or an `opcode` from 13 to 15, yields an all-zero result.
- R4: The compare opcodes are 0 (equal), 1 (signed less-than), 2 (unsigned less-than), 3 (signed less-or-equal) and 4 (unsigned less-or-equal). Each lane becomes all ones when true and all zeros when false.
- R5: Opcode 5 (signed add) and opcode 7 (signed subtract, a minus b) saturate each lane to the range -2^(w-1) .. 2^(w-1)-1, where w is the lane width.
- R6: Opcode 6 (unsigned add) and opcode 8 (unsigned subtract) saturate each lane to the range 0 .. 2^w-1.
- R7: The halving opcodes are 9 (signed add), 10 (unsigned add), 11 (signed subtract) and 12 (unsigned subtract). Each returns the exact sum or difference divided by two and rounded toward minus infinity, taken modulo 2^w.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation present this cycle |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| opcode | input | 4 | Operation select |
| lane_sz | input | 2 | Lane size select |
| out_vld | output | 1 | Result valid strobe |
| out_res | output | 32 | Registered result |

## Verification
The lane-level checks assume that `opcode` and the operands are stable, known values whenever they are evaluated. The bench therefore drives every input on the falling edge and never leaves one floating. The register-level properties assume that `in_vld` is a clean level sampled at the rising edge. The stimulus sweeps every opcode, including the reserved ones, across all four lane-size codes. It combines the sign-boundary corner words with pseudo-random words, so the saturation and reserved-zero properties see both their triggering and their non-triggering sides.

// File: rtl/lmalu_pkg.sv
package lmalu_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_EQ    = 4'd0;
  localparam logic [OP_W-1:0] OP_LT    = 4'd1;
  localparam logic [OP_W-1:0] OP_LTU   = 4'd2;
  localparam logic [OP_W-1:0] OP_LE    = 4'd3;
  localparam logic [OP_W-1:0] OP_LEU   = 4'd4;
  localparam logic [OP_W-1:0] OP_ADDS  = 4'd5;
  localparam logic [OP_W-1:0] OP_ADDSU = 4'd6;
  localparam logic [OP_W-1:0] OP_SUBS  = 4'd7;
  localparam logic [OP_W-1:0] OP_SUBSU = 4'd8;
  localparam logic [OP_W-1:0] OP_HADD  = 4'd9;
  localparam logic [OP_W-1:0] OP_HADDU = 4'd10;
  localparam logic [OP_W-1:0] OP_HSUB  = 4'd11;
  localparam logic [OP_W-1:0] OP_HSUBU = 4'd12;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_BYTE = 2'b10;

  // operands are sign-extended when this returns 1
  function automatic logic op_signed(input logic [OP_W-1:0] op);
    case (op)
      OP_LT, OP_LE, OP_ADDS, OP_SUBS, OP_HADD, OP_HSUB: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_is_cmp(input logic [OP_W-1:0] op);
    return op <= OP_LEU;
  endfunction

  function automatic logic op_defined(input logic [OP_W-1:0] op);
    return op <= OP_HSUBU;
  endfunction
endpackage

// File: rtl/lmalu_lane.sv
module lmalu_lane
  import lmalu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [OP_W-1:0] op,
  output logic [W-1:0]    y
);
  localparam int XW = W + 2;

  logic          sgn;
  logic [XW-1:0] ea, eb, sum, dif;
  logic          lane_eq, lane_lt;
  logic [W-1:0]  sat_sum, sat_dif;

  function automatic logic [W-1:0] clamp(input logic [XW-1:0] v, input logic s);
    if (s) begin
      if (v[XW-1:W-1] == '0 || v[XW-1:W-1] == '1) return v[W-1:0];
      return v[XW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    end
    if (v[XW-1:W] == 2'b00) return v[W-1:0];
    return v[XW-1] ? {W{1'b0}} : {W{1'b1}};
  endfunction

  always_comb begin
    sgn     = op_signed(op);
    ea      = sgn ? {{2{a[W-1]}}, a} : {2'b00, a};
    eb      = sgn ? {{2{b[W-1]}}, b} : {2'b00, b};
    sum     = ea + eb;
    dif     = ea - eb;
    lane_eq = (a == b);
    lane_lt = dif[XW-1];
    sat_sum = clamp(sum, sgn);
    sat_dif = clamp(dif, sgn);
  end

  always_comb begin
    case (op)
      OP_EQ:                y = {W{lane_eq}};
      OP_LT, OP_LTU:        y = {W{lane_lt}};
      OP_LE, OP_LEU:        y = {W{lane_lt | lane_eq}};
      OP_ADDS, OP_ADDSU:    y = sat_sum;
      OP_SUBS, OP_SUBSU:    y = sat_dif;
      OP_HADD, OP_HADDU:    y = sum[W:1];
      OP_HSUB, OP_HSUBU:    y = dif[W:1];
      default:              y = '0;
    endcase
  end

  always_comb begin
    if (op_is_cmp(op))
      assert_cmp_mask_R4: assert (y == '0 || y == '1);
    if (op == OP_ADDSU)
      assert_usat_add_no_wrap_R6: assert (y >= a);
    if (op == OP_SUBSU)
      assert_usat_sub_no_wrap_R6: assert (y <= a);
    if (op == OP_ADDS && !b[W-1])
      assert_ssat_add_no_wrap_R5: assert ($signed(y) >= $signed(a));
  end
endmodule

// File: rtl/lmalu_packed.sv
module lmalu_packed
  import lmalu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] y
);
  localparam int N_LANES = DATA_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    lmalu_lane #(.W(LANE_W)) u_lane (
      .a (a[i*LANE_W +: LANE_W]),
      .b (b[i*LANE_W +: LANE_W]),
      .op(op),
      .y (y[i*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/lmalu_top.sv
module lmalu_top
  import lmalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [OP_W-1:0]   opcode,
  input  logic [1:0]        lane_sz,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_res
);
  localparam int N_SZ = 3;

  logic [DATA_W-1:0] sz_res [N_SZ];
  logic              req_legal;
  logic [DATA_W-1:0] next_res;

  for (genvar k = 0; k < N_SZ; k++) begin : g_size
    lmalu_packed #(.DATA_W(DATA_W), .LANE_W(DATA_W >> k)) u_pk (
      .a (src_a),
      .b (src_b),
      .op(opcode),
      .y (sz_res[k])
    );
  end

  always_comb begin
    req_legal = op_defined(opcode) && (lane_sz != 2'b11);
    case (lane_sz)
      SZ_WORD: next_res = sz_res[0];
      SZ_HALF: next_res = sz_res[1];
      SZ_BYTE: next_res = sz_res[2];
      default: next_res = '0;
    endcase
    if (!req_legal) next_res = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_res <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_res <= next_res;
    end
  end

  assert_vld_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_vld_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res));
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (lane_sz == 2'b11 || opcode > OP_HSUBU)) |=> out_res == '0);
endmodule

// File: tb/lmalu_top_bench.sv
module lmalu_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [31:0] src_a = '0, src_b = '0;
  logic [3:0]  opcode = '0;
  logic [1:0]  lane_sz = '0;
  logic        out_vld;
  logic [31:0] out_res;

  int n_chk = 0, n_fail = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  lmalu_top u_lmalu_top (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_a(src_a), .src_b(src_b),
    .opcode(opcode), .lane_sz(lane_sz), .out_vld(out_vld), .out_res(out_res)
  );

  function automatic longint clip(longint v, longint lo, longint hi);
    return v < lo ? lo : (v > hi ? hi : v);
  endfunction

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, int op, int sz);
    int w, n;
    logic [31:0] res = '0;
    if (sz == 3 || op > 12) return '0;
    w = 32 >> sz;
    n = 32 / w;
    for (int i = 0; i < n; i++) begin
      longint mask = (64'sd1 <<< w) - 1;
      longint half = 64'sd1 <<< (w - 1);
      longint ua = longint'((a >> (i*w))) & mask;
      longint ub = longint'((b >> (i*w))) & mask;
      longint sa = ua >= half ? ua - (mask + 1) : ua;
      longint sb = ub >= half ? ub - (mask + 1) : ub;
      longint r;
      case (op)
        0: r = (ua == ub) ? mask : 0;
        1: r = (sa < sb) ? mask : 0;
        2: r = (ua < ub) ? mask : 0;
        3: r = (sa <= sb) ? mask : 0;
        4: r = (ua <= ub) ? mask : 0;
        5: r = clip(sa + sb, -half, half - 1);
        6: r = clip(ua + ub, 0, mask);
        7: r = clip(sa - sb, -half, half - 1);
        8: r = clip(ua - ub, 0, mask);
        9: r = (sa + sb) >>> 1;
        10: r = (ua + ub) >>> 1;
        11: r = (sa - sb) >>> 1;
        default: r = (ua - ub) >>> 1;
      endcase
      res = res | (32'(r & mask) << (i*w));
    end
    return res;
  endfunction

  function automatic string req_tag(int op, int sz);
    string t;
    if (sz == 3 || op > 12) t = "R3";
    else if (op <= 4) t = "R4";
    else if (op == 5 || op == 7) t = "R5";
    else if (op == 6 || op == 8) t = "R6";
    else t = "R7";
    // packed lane sizes also exercise lane independence
    if (sz == 1 || sz == 2) t = {"R2/", t};
    return t;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] a, logic [31:0] b, int op, int sz);
    @(negedge clk);
    src_a = a; src_b = b; opcode = 4'(op); lane_sz = 2'(sz); in_vld = 1'b1;
    @(posedge clk);
    #1;
    check("R1 valid", 32'(out_vld), 32'd1);
    check(req_tag(op, sz), out_res, model(a, b, op, sz));
  endtask

  function automatic logic [31:0] next_rand(logic [31:0] s);
    s = s ^ (s << 13);
    s = s ^ (s >> 17);
    return s ^ (s << 5);
  endfunction

  logic [31:0] corners [8];
  logic [31:0] held;

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8080_8080; corners[3] = 32'h7F7F_7F7F;
    corners[4] = 32'h8000_8000; corners[5] = 32'h7FFF_7FFF;
    corners[6] = 32'h8000_0000; corners[7] = 32'h0101_7FFF;

    repeat (2) @(posedge clk);
    #1;
    check("R1 reset vld", 32'(out_vld), 32'd0);
    check("R1 reset res", out_res, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int sz = 0; sz < 4; sz++)
      for (int op = 0; op < 16; op++) begin
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run_op(corners[i], corners[j], op, sz);
        for (int k = 0; k < 24; k++) begin
          logic [31:0] ra, rb;
          seed = next_rand(seed); ra = seed;
          seed = next_rand(seed); rb = seed;
          run_op(ra, rb, op, sz);
        end
      end

    // R2 lane independence: byte add where only the low lane overflows
    run_op(32'h0000_00FF, 32'h0000_0001, 6, 2);
    check("R2 no carry", out_res, 32'h0000_00FF);

    // R1 hold: an idle cycle with changed inputs leaves the result alone
    run_op(32'h0000_0003, 32'h0000_0005, 10, 0);
    held = out_res;
    @(negedge clk);
    in_vld = 1'b0; src_a = 32'hDEAD_BEEF; opcode = 4'd5;
    @(posedge clk);
    #1;
    check("R1 idle vld", 32'(out_vld), 32'd0);
    check("R1 idle hold", out_res, held);
    check("R1 held value", held, 32'd4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule